// File: doc/BRIEF.md
# Forwarding Three-Register ALU Pipeline

This block is a compact in-order datapath that runs register-register and register-immediate integer ALU instructions. Instructions flow through fetch, decode with register read, execute, and write-back. Three pipeline registers separate these stages. A small instruction store is indexed by the program counter, which steps by 4 for each fetch. Operands come from a register file with two read ports and one write port. A result the pipeline has not yet written is forwarded straight into the operand path, so dependent instructions can issue back to back without waiting.

A `stall` input stops fetching while the work already in flight runs to completion. Bubbles fill in behind it. A small drain controller with four named states reports when the pipeline is empty, so the register file then holds exactly the programmer-visible result of every instruction fetched so far. The states and transitions:
- `ST_RUN` goes to `ST_DRAIN1` on a stalled edge.
- `ST_DRAIN1` goes to `ST_DRAIN2` on a stalled edge.
- `ST_DRAIN2` goes to `ST_IDLE` on a stalled edge.
- `ST_IDLE` stays put while stall is held.
- Any state returns to `ST_RUN` on an edge with stall low.

Each cycle at most one instruction completes. It is reported on the retire port together with its address, destination and result.

Top module: `fwdp_core`

## Requirements
- R1: While `rst` is high and on the cycle after it, `ret_valid` and `drained` are 0. The registers and the PC restart at zero.
- R2: Instructions retire in fetch order, one per cycle at most. Each retired `ret_pc` is the previous retired address plus 4, modulo 4·2^IMEM_AW. `ret_rd` is the destination field, bits [6:4].
- R3: The operation code in bits [2:0] selects the result: 0 add, 1 subtract (A−B), 2 and, 3 or, 4 xor, 5 signed set-less-than (result 1 or 0). Codes 6 and 7 yield 0.
- R4: When bit 3 is 1, operand B is the sign-extended immediate in bits [31:13]. When bit 3 is 0, operand B is the register named by bits [12:10]. Operand A is always the register named by bits [9:7].
- R5: An instruction that reads the destination of the instruction directly before it receives that instruction's new result, with no added cycles.
- R6: An instruction that reads the destination of the instruction two before it receives the new value, because a register-file read returns the value being written in the same cycle.
- R7: Register 0 always reads as 0. A write to it is discarded. A result headed for register 0 is never forwarded.
- R8: When `stall` has been high on the last three or more rising edges, `drained` is 1 and `ret_valid` is 0. Otherwise `drained` is 0. While stalled the PC does not move and no instruction is fetched.
- R9: After `stall` falls, fetching resumes at the first instruction not yet fetched. No instruction is skipped or repeated.
- R10: After reset is released with `stall` low, the first instruction retires on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Stop fetching and drain in-flight work |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IMEM_AW | Instruction store word address |
| imem_wdata | input | 32 | Instruction word to store |
| drained | output | 1 | Pipeline empty under stall |
| ret_valid | output | 1 | An instruction completes this cycle |
| ret_pc | output | IMEM_AW+2 | Byte address of the completing instruction |
| ret_rd | output | REG_AW | Destination register of the completing instruction |
| ret_data | output | XLEN | Result of the completing instruction |

## Verification
The bench goes after several corner cases:
- Back-to-back dependencies, where a design without execute-stage forwarding would return the stale register value.
- Distance-two dependencies, where a register file without same-cycle write-through would hand back the old value.
- A write to register 0 followed immediately by a read of it, where a design that forwards or stores register-0 results would return a non-zero value.
- Stall pulses of one, two, exactly three and many cycles. A controller that counts wrongly would raise `drained` early or late. A PC that moves under stall would skip or repeat an instruction, which shows up as a break in the retired address sequence.

// File: rtl/fwdp_pkg.sv
package fwdp_pkg;

    // ALU operation selector carried in instruction bits [2:0]
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SLT  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    // Drain controller states
    typedef enum logic [1:0] {
        ST_RUN,
        ST_DRAIN1,
        ST_DRAIN2,
        ST_IDLE
    } drain_st_e;

    localparam int ILEN       = 32;
    localparam int OPC_W      = 3;
    localparam int IMMSEL_BIT = 3;
    localparam int RD_LSB     = 4;

endpackage

// File: rtl/fwdp_alu.sv
module fwdp_alu
    import fwdp_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            OP_RSV6: y = '0;
            OP_RSV7: y = '0;
        endcase
    end
endmodule

// File: rtl/fwdp_regfile.sv
module fwdp_regfile #(
    parameter int W  = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_data_a,
    output logic [W-1:0]  rd_data_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);
    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [NREG];
    logic         wr_live;

    assign wr_live = wr_en && (wr_addr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_live) begin
            regs[wr_addr] <= wr_data;
        end
    end

    // Same-cycle write-through; register 0 is hard zero
    always_comb begin
        if (rd_addr_a == '0)                        rd_data_a = '0;
        else if (wr_live && wr_addr == rd_addr_a)   rd_data_a = wr_data;
        else                                        rd_data_a = regs[rd_addr_a];

        if (rd_addr_b == '0)                        rd_data_b = '0;
        else if (wr_live && wr_addr == rd_addr_b)   rd_data_b = wr_data;
        else                                        rd_data_b = regs[rd_addr_b];
    end
endmodule

// File: rtl/fwdp_imem.sv
module fwdp_imem #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fwdp_drain_ctrl.sv
module fwdp_drain_ctrl
    import fwdp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stall,
    output logic drained
);
    drain_st_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_RUN;
        else     st <= st_nx;
    end

    always_comb begin
        unique case (st)
            ST_RUN:    st_nx = stall ? ST_DRAIN1 : ST_RUN;
            ST_DRAIN1: st_nx = stall ? ST_DRAIN2 : ST_RUN;
            ST_DRAIN2: st_nx = stall ? ST_IDLE   : ST_RUN;
            ST_IDLE:   st_nx = stall ? ST_IDLE   : ST_RUN;
        endcase
    end

    always_comb begin
        drained = (st == ST_IDLE);
    end
endmodule

// File: rtl/fwdp_core.sv
module fwdp_core
    import fwdp_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int REG_AW  = 3,
    parameter int IMEM_AW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_waddr,
    input  logic [ILEN-1:0]    imem_wdata,
    output logic               drained,
    output logic               ret_valid,
    output logic [IMEM_AW+1:0] ret_pc,
    output logic [REG_AW-1:0]  ret_rd,
    output logic [XLEN-1:0]    ret_data
);
    localparam int PCW    = IMEM_AW + 2;
    localparam int RA_LSB = RD_LSB + REG_AW;
    localparam int RB_LSB = RA_LSB + REG_AW;
    localparam int IMM_LSB = RB_LSB + REG_AW;
    localparam int IMM_W  = ILEN - IMM_LSB;

    // Fetch
    logic [PCW-1:0]  pc;
    logic [ILEN-1:0] fetch_word;

    always_ff @(posedge clk) begin
        if (rst)         pc <= '0;
        else if (!stall) pc <= pc + PCW'(4);
    end

    fwdp_imem #(.W(ILEN), .AW(IMEM_AW)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (pc[PCW-1:2]),
        .rdata (fetch_word)
    );

    // Fetch / decode register
    logic            fd_valid;
    logic [ILEN-1:0] fd_instr;
    logic [PCW-1:0]  fd_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            fd_valid <= 1'b0;
            fd_instr <= '0;
            fd_pc    <= '0;
        end else begin
            fd_valid <= !stall;
            fd_instr <= stall ? '0 : fetch_word;
            fd_pc    <= pc;
        end
    end

    // Decode and register read
    logic [REG_AW-1:0] dec_rd, dec_ra, dec_rb;
    logic [XLEN-1:0]   dec_imm, rf_a, rf_b;
    logic              wb_en;
    logic [REG_AW-1:0] xw_rd;
    logic [XLEN-1:0]   xw_res;
    logic              xw_valid;
    logic [PCW-1:0]    xw_pc;

    assign dec_rd  = fd_instr[RD_LSB +: REG_AW];
    assign dec_ra  = fd_instr[RA_LSB +: REG_AW];
    assign dec_rb  = fd_instr[RB_LSB +: REG_AW];
    assign dec_imm = {{(XLEN-IMM_W){fd_instr[ILEN-1]}}, fd_instr[ILEN-1:IMM_LSB]};
    assign wb_en   = xw_valid;

    fwdp_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_addr_a (dec_ra),
        .rd_addr_b (dec_rb),
        .rd_data_a (rf_a),
        .rd_data_b (rf_b),
        .wr_en     (wb_en),
        .wr_addr   (xw_rd),
        .wr_data   (xw_res)
    );

    // Decode / execute register
    logic              de_valid, de_immsel;
    logic [PCW-1:0]    de_pc;
    alu_op_e           de_op;
    logic [REG_AW-1:0] de_rd, de_ra, de_rb;
    logic [XLEN-1:0]   de_va, de_vb, de_imm;

    always_ff @(posedge clk) begin
        if (rst) begin
            de_valid  <= 1'b0;
            de_immsel <= 1'b0;
            de_pc     <= '0;
            de_op     <= OP_ADD;
            de_rd     <= '0;
            de_ra     <= '0;
            de_rb     <= '0;
            de_va     <= '0;
            de_vb     <= '0;
            de_imm    <= '0;
        end else begin
            de_valid  <= fd_valid;
            de_immsel <= fd_instr[IMMSEL_BIT];
            de_pc     <= fd_pc;
            de_op     <= alu_op_e'(fd_instr[OPC_W-1:0]);
            de_rd     <= dec_rd;
            de_ra     <= dec_ra;
            de_rb     <= dec_rb;
            de_va     <= rf_a;
            de_vb     <= rf_b;
            de_imm    <= dec_imm;
        end
    end

    // Execute with forwarding from the execute / write-back register
    logic            fwd_a, fwd_b;
    logic [XLEN-1:0] opa, opb_reg, opb, alu_y;

    always_comb begin
        fwd_a   = xw_valid && (xw_rd != '0) && (xw_rd == de_ra);
        fwd_b   = xw_valid && (xw_rd != '0) && (xw_rd == de_rb);
        opa     = fwd_a ? xw_res : de_va;
        opb_reg = fwd_b ? xw_res : de_vb;
        opb     = de_immsel ? de_imm : opb_reg;
    end

    fwdp_alu #(.W(XLEN)) u_alu (
        .op (de_op),
        .a  (opa),
        .b  (opb),
        .y  (alu_y)
    );

    // Execute / write-back register
    always_ff @(posedge clk) begin
        if (rst) begin
            xw_valid <= 1'b0;
            xw_pc    <= '0;
            xw_rd    <= '0;
            xw_res   <= '0;
        end else begin
            xw_valid <= de_valid;
            xw_pc    <= de_pc;
            xw_rd    <= de_rd;
            xw_res   <= alu_y;
        end
    end

    fwdp_drain_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .drained (drained)
    );

    assign ret_valid = xw_valid;
    assign ret_pc    = xw_pc;
    assign ret_rd    = xw_rd;
    assign ret_data  = xw_res;
endmodule

// File: rtl/fwdp_core_chk.sv
module fwdp_core_chk #(
    parameter int XLEN    = 32,
    parameter int REG_AW  = 3,
    parameter int IMEM_AW = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               stall,
    input logic               drained,
    input logic               ret_valid,
    input logic [IMEM_AW+1:0] ret_pc,
    input logic [REG_AW-1:0]  ret_rd,
    input logic [XLEN-1:0]    ret_data
);
    localparam int PCW = IMEM_AW + 2;

    // R1: reset empties the pipeline and the drain controller
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ret_valid && !drained));

    // R2: consecutive retirements are consecutive addresses
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && $past(ret_valid)) |-> (ret_pc == $past(ret_pc) + PCW'(4)));

    // R8: nothing retires once drained
    a_r8_drained_quiet: assert property (@(posedge clk) disable iff (rst)
        drained |-> !ret_valid);

    // R8: drained only follows a stalled edge
    a_r8_drained_needs_stall: assert property (@(posedge clk) disable iff (rst)
        drained |-> $past(stall));

    // R9: releasing stall leaves the drained state at once
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        !stall |=> !drained);
endmodule

bind fwdp_core fwdp_core_chk #(
    .XLEN    (XLEN),
    .REG_AW  (REG_AW),
    .IMEM_AW (IMEM_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .drained   (drained),
    .ret_valid (ret_valid),
    .ret_pc    (ret_pc),
    .ret_rd    (ret_rd),
    .ret_data  (ret_data)
);

// File: tb/fwdp_core_tb.sv
module fwdp_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int RAW  = 3;
    localparam int IAW  = 5;
    localparam int NWORD = 1 << IAW;
    localparam int PCMOD = 4 * NWORD;
    localparam int NCYC  = 700;

    logic             clk = 1'b0;
    logic             rst;
    logic             stall;
    logic             imem_we;
    logic [IAW-1:0]   imem_waddr;
    logic [31:0]      imem_wdata;
    logic             drained;
    logic             ret_valid;
    logic [IAW+1:0]   ret_pc;
    logic [RAW-1:0]   ret_rd;
    logic [XLEN-1:0]  ret_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwdp_core #(.XLEN(XLEN), .REG_AW(RAW), .IMEM_AW(IAW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .stall      (stall),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .drained    (drained),
        .ret_valid  (ret_valid),
        .ret_pc     (ret_pc),
        .ret_rd     (ret_rd),
        .ret_data   (ret_data)
    );

    // Instruction word: [2:0] op, [3] imm select, [6:4] rd, [9:7] ra, [12:10] rb, [31:13] imm
    function automatic logic [31:0] enc(int op, int isel, int rd, int ra, int rb, int imm);
        logic [18:0] im;
        im = 19'(imm);
        return {im, 3'(rb), 3'(ra), 3'(rd), 1'(isel), 3'(op)};
    endfunction

    function automatic logic [31:0] prog_word(int idx);
        case (idx)
            0:  return enc(0, 1, 1, 0, 0, 5);
            1:  return enc(0, 1, 2, 1, 0, -3);
            2:  return enc(0, 0, 3, 1, 2, 0);
            3:  return enc(1, 0, 4, 2, 3, 0);
            4:  return enc(5, 0, 5, 4, 1, 0);
            5:  return enc(2, 0, 6, 3, 4, 0);
            6:  return enc(3, 0, 7, 4, 2, 0);
            7:  return enc(4, 0, 1, 7, 3, 0);
            8:  return enc(0, 1, 0, 1, 0, 99);
            9:  return enc(0, 0, 2, 0, 0, 0);
            10: return enc(6, 0, 3, 1, 2, 0);
            11: return enc(5, 1, 4, 4, 0, -262144);
            12: return enc(1, 1, 5, 5, 0, -1);
            13: return enc(4, 1, 6, 6, 0, 32'h3ffff);
            14: return enc(7, 1, 7, 1, 0, 3);
            default: return enc(idx % 6, idx % 2, (idx % 7) + 1, (idx + 3) % 8, (idx + 5) % 8, idx * 37 - 300);
        endcase
    endfunction

    function automatic string tag_of(int idx);
        case (idx)
            0, 11, 12, 13: return "R4";
            1:             return "R5";
            2:             return "R6";
            8, 9:          return "R7";
            default:       return "R3";
        endcase
    endfunction

    function automatic bit sched(int cyc);
        if (cyc >= 20 && cyc < 26)   return 1'b1;
        if (cyc == 40)               return 1'b1;
        if (cyc >= 60 && cyc < 62)   return 1'b1;
        if (cyc >= 100 && cyc < 104) return 1'b1;
        if (cyc >= 150 && cyc < 153) return 1'b1;
        if (cyc > 200 && (cyc % 7) == 3) return 1'b1;
        if (cyc > 400 && (cyc % 11) < 4) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference state
    logic [31:0] mregs [8];
    int exp_pc;
    int retired;
    int stall_run;
    int edges;

    task automatic model_retire();
        logic [31:0] w, a, b, r, imm;
        int idx, op, rd;
        idx = exp_pc / 4;
        w   = prog_word(idx);
        op  = int'(w[2:0]);
        rd  = int'(w[6:4]);
        imm = {{13{w[31]}}, w[31:13]};
        a   = mregs[w[9:7]];
        b   = w[3] ? imm : mregs[w[12:10]];
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: r = 32'd0;
        endcase
        chk(ret_pc == (IAW+2)'(exp_pc), (stall_run == 0) ? "R9" : "R2", "retire address", 32'(ret_pc), 32'(exp_pc));
        chk(ret_rd == 3'(rd), "R2", "retire destination", 32'(ret_rd), 32'(rd));
        chk(ret_data == r, tag_of(idx), "retire result", ret_data, r);
        if (rd != 0) mregs[rd] = r;
        exp_pc = (exp_pc + 4) % PCMOD;
        retired++;
    endtask

    initial begin
        rst = 1'b1;
        stall = 1'b0;
        imem_we = 1'b0;
        imem_waddr = '0;
        imem_wdata = '0;
        for (int i = 0; i < 8; i++) mregs[i] = '0;
        exp_pc = 0;
        retired = 0;
        stall_run = 0;
        edges = 0;

        for (int i = 0; i < NWORD; i++) begin
            @(negedge clk);
            imem_we = 1'b1;
            imem_waddr = IAW'(i);
            imem_wdata = prog_word(i);
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(negedge clk);
        chk(!ret_valid, "R1", "ret_valid in reset", 32'(ret_valid), 0);
        chk(!drained, "R1", "drained in reset", 32'(drained), 0);
        rst = 1'b0;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            stall = sched(cyc);
            @(posedge clk);
            stall_run = stall ? stall_run + 1 : 0;
            edges++;
            @(negedge clk);
            if (edges == 1) begin
                chk(!ret_valid, "R1", "ret_valid after reset", 32'(ret_valid), 0);
                chk(!drained, "R1", "drained after reset", 32'(drained), 0);
            end
            if (edges <= 3)
                chk(ret_valid == (edges == 3), "R10", "first retire latency", 32'(ret_valid), 32'(edges == 3));
            chk(drained == (stall_run >= 3), "R8", "drained flag", 32'(drained), 32'(stall_run >= 3));
            if (stall_run >= 3)
                chk(!ret_valid, "R8", "retire while drained", 32'(ret_valid), 0);
            if (ret_valid) model_retire();
        end

        chk(retired > 300, "R2", "retire count", 32'(retired), 300);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule